// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This unit keeps the 16-bit stack pointer of a small 8-bit processor core. The stack lives in data memory and grows from high addresses toward low ones. Each cycle the core may request one stack operation: a single-byte push or pop, or a two-byte return-address push (on a call or an interrupt entry) or pop (on a return). The unit returns the one or two memory addresses for that operation combinationally in the same cycle. At the next clock edge it moves the pointer by the step that the operation needs.

Software sees the pointer as two byte-wide registers, an upper byte and a lower byte. Both bytes can always be read, and either one can be written. A byte write takes effect on the next edge and wins over a stack operation requested in the same cycle. A status output is raised whenever the pointer has reached the bottom limit of the stack region or gone below it, which catches a stack that has grown too deep.

The push convention is store-then-decrement. The pop convention is increment-then-load. A return address goes out low byte first, at the higher address, and comes back high byte first.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer holds 0x02FF, the last address of the data RAM. This is parameter `RESET_SP`.
- R2: Byte push (op_i = 1): addr_a_o = addr_b_o = current pointer. The pointer becomes pointer − 1 on the next edge.
- R3: Byte pop (op_i = 2): addr_a_o = addr_b_o = pointer + 1. The pointer becomes pointer + 1 on the next edge.
- R4: Return-address push (op_i = 3): the low byte goes to addr_a_o = pointer and the high byte to addr_b_o = pointer − 1. The pointer becomes pointer − 2.
- R5: Return-address pop (op_i = 4): the high byte is read from addr_a_o = pointer + 1 and the low byte from addr_b_o = pointer + 2. The pointer becomes pointer + 2.
- R6: op_i = 0 (idle) and the unused codes 5, 6 and 7 leave the pointer unchanged. In those cycles addr_a_o = addr_b_o = pointer.
- R7: With wr_en_i high, wr_data_i is loaded into the upper byte (wr_hi_i = 1) or the lower byte (wr_hi_i = 0) on the next edge. The other byte keeps its value.
- R8: A byte write in the same cycle as a stack operation wins: the operation has no effect on the pointer.
- R9: sp_hi_o and sp_lo_o always show the upper and lower byte of the pointer, and sp_o shows the whole pointer.
- R10: low_o is 1 exactly when the pointer is at or below 0x0060 (parameter `LOW_LIMIT`).
- R11: All pointer and address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Stack operation code (0 idle, 1 byte push, 2 byte pop, 3 return push, 4 return pop) |
| wr_en_i | input | 1 | Software byte write strobe |
| wr_hi_i | input | 1 | Byte select for the write: 1 upper, 0 lower |
| wr_data_i | input | 8 | Byte to be written |
| addr_a_o | output | 16 | First memory address of the current operation |
| addr_b_o | output | 16 | Second memory address (same as the first for byte operations) |
| sp_o | output | 16 | Full pointer |
| sp_hi_o | output | 8 | Upper byte of the pointer |
| sp_lo_o | output | 8 | Lower byte of the pointer |
| low_o | output | 1 | Pointer is at or below the low limit |

## Verification
The assertions check the step rules on every clock: −1, +1, −2 and +2 for the four operations. They also check that the pointer holds still on idle or unused codes, that a byte write loads the chosen byte and leaves the other alone, and that the two addresses of a return-address operation are adjacent in the right direction. The bench scenarios cover the rest. They check the reset value, the low-limit flag as the pointer crosses 0x0061, 0x0060 and 0x005F, wrap-around through zero in both directions, and a write colliding with each kind of operation. The ordering of bytes within return-address pushes and pops is confirmed against an independent model over long random sequences.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [2:0] {
    SOP_IDLE    = 3'd0,
    SOP_PUSH_B  = 3'd1,
    SOP_POP_B   = 3'd2,
    SOP_PUSH_RA = 3'd3,
    SOP_POP_RA  = 3'd4
  } sop_e;

  // Unused codes fold onto idle.
  function automatic sop_e decode_op(input logic [2:0] code);
    case (code)
      3'd1:    return SOP_PUSH_B;
      3'd2:    return SOP_POP_B;
      3'd3:    return SOP_PUSH_RA;
      3'd4:    return SOP_POP_RA;
      default: return SOP_IDLE;
    endcase
  endfunction

  function automatic logic op_moves(input sop_e op);
    return op != SOP_IDLE;
  endfunction

  function automatic logic op_is_push(input sop_e op);
    return (op == SOP_PUSH_B) || (op == SOP_PUSH_RA);
  endfunction

  // Step size in bytes.
  function automatic logic [1:0] op_step(input sop_e op);
    case (op)
      SOP_PUSH_B, SOP_POP_B:   return 2'd1;
      SOP_PUSH_RA, SOP_POP_RA: return 2'd2;
      default:                 return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sp_addr_gen.sv
module sp_addr_gen
  import sp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] sp_i,
  input  sop_e          op_i,
  output logic [AW-1:0] nxt_o,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o
);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] sp, input sop_e op);
    logic [AW-1:0] step;
    step = AW'(op_step(op));
    if (op_is_push(op)) return sp - step;
    return sp + step;
  endfunction

  function automatic logic [AW-1:0] first_addr(input logic [AW-1:0] sp, input sop_e op);
    if (op == SOP_POP_B || op == SOP_POP_RA) return sp + AW'(1);
    return sp;
  endfunction

  function automatic logic [AW-1:0] second_addr(input logic [AW-1:0] sp, input sop_e op);
    case (op)
      SOP_PUSH_RA: return sp - AW'(1);
      SOP_POP_RA:  return sp + AW'(2);
      default:     return first_addr(sp, op);
    endcase
  endfunction

  always_comb begin
    nxt_o    = next_ptr(sp_i, op_i);
    addr_a_o = first_addr(sp_i, op_i);
    addr_b_o = second_addr(sp_i, op_i);
  end

endmodule

// File: rtl/sp_byte_bank.sv
module sp_byte_bank #(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] RESET_SP = 16'h02FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          wr_hi_i,
  input  logic [7:0]    wr_data_i,
  input  logic          mv_en_i,
  input  logic [AW-1:0] nxt_i,
  output logic [AW-1:0] sp_o
);

  localparam int NB  = AW / 8;
  localparam int TOP = NB - 1;

  // Write strobe per byte lane.
  logic [NB-1:0] lane_wr;

  for (genvar gi = 0; gi < NB; gi++) begin : g_lane
    localparam logic [7:0] RST_B = RESET_SP[gi*8 +: 8];

    assign lane_wr[gi] = wr_en_i && (wr_hi_i ? (gi == TOP) : (gi == 0));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sp_o[gi*8 +: 8] <= RST_B;
      else if (lane_wr[gi]) sp_o[gi*8 +: 8] <= wr_data_i;
      else if (!wr_en_i && mv_en_i) sp_o[gi*8 +: 8] <= nxt_i[gi*8 +: 8];
    end
  end

  // R7
  hi_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_hi_i) |=> (sp_o[AW-1 -: 8] == $past(wr_data_i)));

  // R7
  lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_hi_i) |=> (sp_o[AW-1 -: 8] == $past(sp_o[AW-1 -: 8]) &&
                               sp_o[7:0] == $past(wr_data_i)));

endmodule

// File: rtl/sp_limit_mon.sv
module sp_limit_mon #(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] LOW_LIMIT = 16'h0060
) (
  input  logic [AW-1:0] sp_i,
  output logic          low_o
);

  function automatic logic at_or_below(input logic [AW-1:0] sp);
    return sp <= LOW_LIMIT;
  endfunction

  assign low_o = at_or_below(sp_i);

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] RESET_SP  = 16'h02FF,
  parameter logic [AW-1:0] LOW_LIMIT = 16'h0060
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic          wr_en_i,
  input  logic          wr_hi_i,
  input  logic [7:0]    wr_data_i,
  output logic [AW-1:0] addr_a_o,
  output logic [AW-1:0] addr_b_o,
  output logic [AW-1:0] sp_o,
  output logic [7:0]    sp_hi_o,
  output logic [7:0]    sp_lo_o,
  output logic          low_o
);

  // Named internal events for the checks.
  sop_e          op_dec;
  logic          op_move;
  logic          op_taken;
  logic [AW-1:0] sp_nxt;

  assign op_dec   = decode_op(op_i);
  assign op_move  = op_moves(op_dec);
  assign op_taken = op_move && !wr_en_i;

  sp_addr_gen #(.AW(AW)) u_addr (
    .sp_i     (sp_o),
    .op_i     (op_dec),
    .nxt_o    (sp_nxt),
    .addr_a_o (addr_a_o),
    .addr_b_o (addr_b_o)
  );

  sp_byte_bank #(.AW(AW), .RESET_SP(RESET_SP)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .mv_en_i   (op_move),
    .nxt_i     (sp_nxt),
    .sp_o      (sp_o)
  );

  sp_limit_mon #(.AW(AW), .LOW_LIMIT(LOW_LIMIT)) u_mon (
    .sp_i  (sp_o),
    .low_o (low_o)
  );

  assign sp_hi_o = sp_o[AW-1 -: 8];
  assign sp_lo_o = sp_o[7:0];

  // R2
  push_b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd1 && !wr_en_i) |=> (sp_o == $past(sp_o) - AW'(1)));

  // R3
  pop_b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && !wr_en_i) |=> (sp_o == $past(sp_o) + AW'(1)));

  // R4
  push_ra_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && !wr_en_i) |=> (sp_o == $past(sp_o) - AW'(2)));

  // R5
  pop_ra_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4 && !wr_en_i) |=> (sp_o == $past(sp_o) + AW'(2)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && (op_i == 3'd0 || op_i > 3'd4)) |=> $stable(sp_o));

  // R4
  push_ra_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3) |-> (addr_a_o - addr_b_o == AW'(1) && addr_a_o == sp_o));

  // R5
  pop_ra_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4) |-> (addr_b_o - addr_a_o == AW'(1) && addr_a_o - sp_o == AW'(1)));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_move) |=> (sp_o[7:0] == $past(sp_o[7:0]) || sp_o[AW-1 -: 8] == $past(sp_o[AW-1 -: 8])));

endmodule

// File: tb/sim_stack_ptr_unit.sv
`timescale 1ns/1ps
module sim_stack_ptr_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic        we, whi;
  logic [7:0]  wd;
  logic [15:0] addr_a, addr_b, sp;
  logic [7:0]  sp_hi, sp_lo;
  logic        low;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_sp;
  bit done = 0;

  always #2.5 clk = ~clk;

  stack_ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .wr_en_i(we), .wr_hi_i(whi),
    .wr_data_i(wd), .addr_a_o(addr_a), .addr_b_o(addr_b), .sp_o(sp),
    .sp_hi_o(sp_hi), .sp_lo_o(sp_lo), .low_o(low)
  );

  function automatic logic [15:0] ex_next(logic [15:0] s, logic [2:0] o,
                                         logic w, logic h, logic [7:0] d);
    if (w) return h ? {d, s[7:0]} : {s[15:8], d};
    case (o)
      3'd1: return s - 16'd1;
      3'd2: return s + 16'd1;
      3'd3: return s - 16'd2;
      3'd4: return s + 16'd2;
      default: return s;
    endcase
  endfunction

  function automatic logic [15:0] ex_a(logic [15:0] s, logic [2:0] o);
    return (o == 3'd2 || o == 3'd4) ? s + 16'd1 : s;
  endfunction

  function automatic logic [15:0] ex_b(logic [15:0] s, logic [2:0] o);
    if (o == 3'd3) return s - 16'd1;
    if (o == 3'd4) return s + 16'd2;
    return ex_a(s, o);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string op_req(logic [2:0] o);
    case (o)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check_state();
    check("R9 sp", sp, m_sp);
    check("R9 hi", {8'h00, sp_hi}, {8'h00, m_sp[15:8]});
    check("R9 lo", {8'h00, sp_lo}, {8'h00, m_sp[7:0]});
    check("R10 low", {15'h0, low}, {15'h0, (m_sp <= 16'h0060)});
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(logic [2:0] o, logic w, logic h, logic [7:0] d);
    logic [15:0] nx;
    op = o; we = w; whi = h; wd = d;
    #1;
    check({op_req(o), " addr_a"}, addr_a, ex_a(m_sp, o));
    check({op_req(o), " addr_b"}, addr_b, ex_b(m_sp, o));
    nx = ex_next(m_sp, o, w, h, d);
    @(negedge clk);
    if (w && o != 3'd0) check("R8 write wins", sp, nx);
    else if (w)         check("R7 byte write", sp, nx);
    else                check({op_req(o), " step"}, sp, nx);
    m_sp = nx;
    check_state();
  endtask

  task automatic set_sp(logic [15:0] v);
    cyc(3'd0, 1'b1, 1'b1, v[15:8]);
    cyc(3'd0, 1'b1, 1'b0, v[7:0]);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; op = 3'd0; we = 1'b0; whi = 1'b0; wd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_sp = 16'h02FF;
    check("R1 reset", sp, 16'h02FF);
    check_state();

    // R10 crossing the limit
    set_sp(16'h0062);
    cyc(3'd1, 0, 0, 0);
    cyc(3'd1, 0, 0, 0);
    cyc(3'd1, 0, 0, 0);
    cyc(3'd2, 0, 0, 0);
    cyc(3'd2, 0, 0, 0);
    // R11 wrap both ways
    set_sp(16'h0001);
    cyc(3'd3, 0, 0, 0);
    cyc(3'd4, 0, 0, 0);
    cyc(3'd1, 0, 0, 0);
    cyc(3'd1, 0, 0, 0);
    cyc(3'd4, 0, 0, 0);
    set_sp(16'hFFFE);
    cyc(3'd4, 0, 0, 0);
    cyc(3'd2, 0, 0, 0);
    // R6 unused codes
    for (int c = 5; c < 8; c++) cyc(3'(c), 0, 0, 0);
    // R8 collisions with each operation
    for (int c = 1; c < 5; c++) cyc(3'(c), 1'b1, c[0], 8'hA0 + 8'(c));
    // R7 upper then lower
    cyc(3'd0, 1, 1, 8'h03);
    cyc(3'd0, 1, 0, 8'h40);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      logic w;
      o = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 15) == 0);
      cyc(o, w, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule